// File: doc/BRIEF.md
# Four-Phase Stepper Sequencer

This block sequences the windings of a two-phase stepper motor with four windings. It drives a 4-bit winding code that steps through a fixed loop of four codes, one code per step. Between steps it counts out a step interval that software or a neighbouring block supplies. A smaller interval gives faster rotation. The direction input picks whether the loop runs forward or backward. Running it backward turns the motor the other way.

The direction input is read only at the cycle in which a step is taken, so the current phase always runs its full interval. When the enable is low, the winding code and the interval count both hold. Raising the enable again resumes the interval from the count it had reached. A one-cycle step strobe marks each new code. A position counter outside the block can count these strobes.

Top module: `stepper_seq`

## Requirements
- R1: While rst_ni is low and right after it rises, phase_o is 4'b1001, step_o is 0 and the interval count is zero.
- R2: With dir_i = 1 (forward), successive steps apply 4'b1001, 4'b0101, 4'b0110, 4'b1010 and then wrap back to 4'b1001 without end.
- R3: With dir_i = 0 (reverse), successive steps walk the same loop backward: 4'b1010, 4'b0110, 4'b0101, 4'b1001, then wrap.
- R4: With en_i held high and interval_i = N constant, a step is taken every N+1 clock cycles. N = 0 steps on every cycle, and N at its all-ones maximum is also honoured.
- R5: step_o is high for exactly the cycles in which a new code has just been applied. phase_o never changes unless step_o is high.
- R6: dir_i is used only on the cycle a step is taken. Toggling it between steps has no effect on phase_o until the next step.
- R7: While en_i is low, phase_o holds, step_o stays 0 and the interval count freezes. When en_i rises again, the remaining part of the interval is counted out.
- R8: If interval_i is lowered below the count already elapsed, a step is taken on the next enabled cycle.
- R9: phase_o always has exactly two of its four bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; low freezes the sequencer |
| dir_i | input | 1 | 1 = forward loop, 0 = reverse loop; read at step cycles only |
| interval_i | input | CNT_W | Step interval N; a step is taken every N+1 enabled cycles |
| phase_o | output | 4 | Winding code |
| step_o | output | 1 | One-cycle strobe marking a newly applied code |

## Verification
The bench builds the block with CNT_W = 8 instead of the default 16. This makes the all-ones interval of 255 short enough to run several full steps at the maximum. Shorter runs cover the zero interval, where a step is taken on every cycle. They also cover interval cuts below the elapsed count, direction toggles between steps, and enable gaps that fall at different points inside an interval. A behavioural model of the winding index and the interval count is compared against both outputs on every clock.

// File: rtl/stp_pkg.sv
package stp_pkg;
  localparam int unsigned PHASES = 4;
  localparam int unsigned IDX_W  = $clog2(PHASES);

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [3:0]       code_t;

  // forward order; reverse walks the index downward
  function automatic code_t idx_to_code(idx_t idx);
    case (idx)
      2'd0:    return 4'b1001;
      2'd1:    return 4'b0101;
      2'd2:    return 4'b0110;
      default: return 4'b1010;
    endcase
  endfunction
endpackage

// File: rtl/stp_interval_timer.sv
module stp_interval_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] interval_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  // >= so a lowered interval ends the phase at once
  assign tick_o = en_i && (cnt_q >= interval_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end

  p_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  p_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
  p_count_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/stp_phase_ctrl.sv
module stp_phase_ctrl
  import stp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic dir_i,
  output idx_t idx_o,
  output logic step_o
);
  idx_t idx_q;
  logic step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      step_q <= 1'b0;
    end else begin
      step_q <= adv_i;
      if (adv_i) idx_q <= dir_i ? idx_q + 1'b1 : idx_q - 1'b1;
    end
  end

  assign idx_o  = idx_q;
  assign step_o = step_q;

  p_fwd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && dir_i) |=> (idx_q == idx_t'($past(idx_q) + 2'd1)));
  p_rev_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !dir_i) |=> (idx_q == idx_t'($past(idx_q) - 2'd1)));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> ($stable(idx_q) && !step_q));
endmodule

// File: rtl/stp_code_map.sv
module stp_code_map
  import stp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  idx_t  idx_i,
  output code_t code_o
);
  assign code_o = idx_to_code(idx_i);

  p_two_on_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(code_o) == 2);
endmodule

// File: rtl/stepper_seq.sv
module stepper_seq
  import stp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             dir_i,
  input  logic [CNT_W-1:0] interval_i,
  output logic [3:0]       phase_o,
  output logic             step_o
);
  logic             tick;
  logic [CNT_W-1:0] cnt;
  idx_t             idx;

  stp_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .interval_i (interval_i),
    .tick_o     (tick),
    .cnt_o      (cnt)
  );

  stp_phase_ctrl u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (tick),
    .dir_i  (dir_i),
    .idx_o  (idx),
    .step_o (step_o)
  );

  stp_code_map u_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_i  (idx),
    .code_o (phase_o)
  );

  p_change_strobed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(phase_o) |-> step_o);
  p_strobe_fresh_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> (cnt == '0));
  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(phase_o) && !step_o));
endmodule

// File: tb/stepper_seq_test.sv
module stepper_seq_test;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          dir = 1'b1;
  logic [CW-1:0] ival = '0;
  logic [3:0]    phase;
  logic          step;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";

  int ref_cnt = 0;
  int ref_idx = 0;
  bit ref_step = 0;
  bit cmp_on = 0;

  always #10 clk = ~clk;

  stepper_seq #(.CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .dir_i(dir),
    .interval_i(ival), .phase_o(phase), .step_o(step)
  );

  function automatic logic [3:0] code_of(int i);
    case (i)
      0: return 4'b1001;
      1: return 4'b0101;
      2: return 4'b0110;
      default: return 4'b1010;
    endcase
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // behavioural reference: winding index and elapsed count
  always @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt = 0; ref_idx = 0; ref_step = 0;
    end else if (en) begin
      if (ref_cnt >= int'(ival)) begin
        ref_cnt = 0;
        ref_idx = dir ? (ref_idx + 1) % 4 : (ref_idx + 3) % 4;
        ref_step = 1;
      end else begin
        ref_cnt = ref_cnt + 1;
        ref_step = 0;
      end
    end else begin
      ref_step = 0;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(tag, phase, code_of(ref_idx));
      chk(tag, {3'b000, step}, {3'b000, ref_step});
      chk("R9", {3'b000, 1'b0}, {3'b000, ($countones(phase) != 2)});
    end
  end

  task automatic cycles(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    cycles(3);
    chk("R1", phase, 4'b1001);
    chk("R1", {3'b000, step}, 4'b0000);
    rst_n = 1'b1;
    cmp_on = 1;
    cycles(2);
    chk("R1", phase, 4'b1001);

    tag = "R2"; en = 1; dir = 1; ival = 8'd3; cycles(22);
    tag = "R4"; ival = 8'd0; cycles(7);
    tag = "R3"; dir = 0; ival = 8'd2; cycles(16);
    tag = "R4"; dir = 1; ival = 8'hFF; cycles(800);
    tag = "R6"; ival = 8'd10;
    for (int k = 0; k < 25; k++) begin dir = ~dir; cycles(3); end
    tag = "R7"; ival = 8'd4;
    for (int k = 0; k < 12; k++) begin en = 0; cycles(k % 3 + 1); en = 1; cycles(k % 5 + 1); end
    en = 0; cycles(5);
    en = 1;
    tag = "R8"; ival = 8'd20; cycles(13);
    ival = 8'd5; cycles(12);
    tag = "R5"; ival = 8'd1; cycles(10);

    cmp_on = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule